// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt output to a processor. Each line passes through a two-flop synchronizer and is captured in a pending register. Capture works either on a rising edge or on the level of the line. A mask register gates which pending levels may compete. An in-service register records the levels that are being handled, so a new request reaches the processor only when its priority is above every level still in service.

The processor answers the interrupt with two acknowledge strobes. The first strobe moves the winning level from pending to in-service. The second strobe returns an 8-bit vector: a programmable 5-bit base in the upper bits and the 3-bit level number in the lower bits. Service ends with an end-of-interrupt command. That command clears either the highest-priority in-service level or a named level, and it can rotate priority so that the level just finished drops to the bottom. In polled mode the interrupt output stays low and the processor reads a poll byte instead.

All control goes through a small synchronous register port: chip select, read strobe, write strobe and one address bit.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low and the mask, pending and in-service registers are zero. The vector base is zero, edge capture is selected, priority is fixed and register reads return the pending register.
- R2: A write to address 1 loads the mask register and a read of address 1 returns it. A pending level whose mask bit is 1 does not raise the interrupt output.
- R3: In edge mode a rising edge on a request line sets its pending bit. The bit stays set after the line falls, until the level is acknowledged. A line held high makes no new request after acknowledge, and a line already high at reset makes no request.
- R4: In level mode the pending bit follows the line, and it clears when the line is withdrawn. After acknowledge the pending bit sets again while the line stays high. The line must be seen low after reset before it can request.
- R5: With fixed priority, level 0 is highest and level 7 is lowest.
- R6: A pending, unmasked level raises the interrupt only when its priority is strictly above that of every in-service level.
- R7: Writing address 0 with bits [7:6]=01 sets the vector base to bits [4:0]. The first acknowledge strobe moves the winning level from pending to in-service. The second strobe drives the vector {base, level} on the vector output, with the valid flag high for one cycle.
- R8: Writing address 0 with bits [7:6]=10 is end-of-interrupt. If bit 3 is 0, it clears the highest-priority in-service bit. If bit 3 is 1, it clears the bit of the level in bits [2:0].
- R9: Writing address 0 with bits [7:6]=00 sets the configuration: bit 0 selects level capture, bit 1 enables rotation and bit 2 selects polled mode. With rotation enabled, each end-of-interrupt makes the cleared level the lowest priority and the next level up the highest.
- R10: In polled mode the interrupt output stays low. Writing address 0 with 0xC2 arms a one-shot poll. The next read of address 0 returns {bit7 = request present, bits[2:0] = winning level} and moves that level to in-service.
- R11: Writing address 0 with 0xC0 or 0xC1 makes later reads of address 0 return the pending or the in-service register.
- R12: An acknowledge sequence with no eligible request returns level 7 with the current base, and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register port select |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 1 | Register address (0 command/status, 1 mask) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered on the read strobe |
| irq_i | input | 8 | Asynchronous request lines |
| int_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Acknowledge strobe, one cycle per pulse |
| vec_o | output | 8 | Vector returned on the second acknowledge |
| vec_valid_o | output | 1 | One-cycle flag for a new vector |

## Verification
Two cases are hard to reach from the ports. The first is a rotated priority order in which a lower-numbered request loses to a higher-numbered one. The stimulus reaches it by enabling rotation and acknowledging level 0. It then finishes level 0 with end-of-interrupt, and raises level 0 again while level 4 is still pending, so that level 4 must win. The second is nesting. The bench holds a lower request pending under an in-service level, then raises a higher one, then clears levels in both ways, non-specific and named, and checks after each step whether the interrupt comes back. A third case is a line already high when reset is released. The bench resets with every line high and confirms that neither capture mode requests until a line falls and rises again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CMD_CFG  = 2'b00,
    CMD_BASE = 2'b01,
    CMD_EOI  = 2'b10,
    CMD_SEL  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic polled;
    logic rotate;
    logic level;
  } cfg_t;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_mode_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1_q, s2_q, prev_q, armed_q, pend_q, set_w;

    // Sync flops reset high: a line already high at reset is not an edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q    <= 1'b1;
        s2_q    <= 1'b1;
        prev_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        s1_q    <= req_i[g];
        s2_q    <= s1_q;
        prev_q  <= s2_q;
        armed_q <= armed_q | ~s2_q;
      end
    end

    assign set_w = level_mode_i ? (s2_q & armed_q) : (s2_q & ~prev_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           pend_q <= 1'b0;
      else if (clr_i[g])     pend_q <= 1'b0;
      else if (level_mode_i) pend_q <= set_w;
      else                   pend_q <= pend_q | set_w;
    end

    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] lowest_i,
  output logic         valid_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rank_o
);
  // N must be a power of two: the wrap relies on truncation.
  always_comb begin
    valid_o = 1'b0;
    lvl_o   = '0;
    rank_o  = '0;
    for (int r = N - 1; r >= 0; r--) begin
      logic [W-1:0] idx;
      idx = lowest_i + W'(r + 1);
      if (vec_i[idx]) begin
        valid_o = 1'b1;
        lvl_o   = idx;
        rank_o  = W'(r);
      end
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int W  = 3,
  parameter int DW = 8,
  localparam int BW = DW - W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  input  logic          cand_ok_i,
  input  logic [W-1:0]  cand_lvl_i,
  input  logic [BW-1:0] base_i,
  output logic          grant_o,
  output logic [DW-1:0] vec_o,
  output logic          vec_valid_o
);
  logic         phase_q;
  logic [W-1:0] lvl_q;

  assign grant_o = ack_i & ~phase_q & cand_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      lvl_q       <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= 1'b0;
      if (ack_i && !phase_q) begin
        phase_q <= 1'b1;
        lvl_q   <= cand_ok_i ? cand_lvl_i : '1;  // no winner: lowest level
      end else if (ack_i && phase_q) begin
        phase_q     <= 1'b0;
        vec_o       <= {base_i, lvl_q};
        vec_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N_IRQ-1:0] irq_i,
  output logic          int_o,
  input  logic          ack_i,
  output logic [DW-1:0] vec_o,
  output logic          vec_valid_o
);
  import irq_pkg::*;

  localparam int LW = $clog2(N_IRQ);
  localparam int BW = DW - LW;

  cfg_t            cfg_q;
  logic [BW-1:0]   base_q;
  logic [N_IRQ-1:0] mask_q, isr_q, pend;
  logic [LW-1:0]   lowest_q, lowest_eff;
  logic            sel_isr_q, poll_q;

  logic            wr_cmd, wr_mask, rd_cmd;
  cmd_e            cmd;
  logic            cand_v, isr_v, cand_ok;
  logic [LW-1:0]   cand_lvl, cand_rank, isr_lvl, isr_rank;
  logic            ack_grant, poll_grant, eoi_hit;
  logic [LW-1:0]   eoi_lvl;
  logic [N_IRQ-1:0] grant_set, isr_clr;
  logic            unused_wdata;

  assign wr_cmd  = cs_i & wr_i & ~addr_i;
  assign wr_mask = cs_i & wr_i & addr_i;
  assign rd_cmd  = cs_i & rd_i & ~addr_i;
  assign cmd     = cmd_e'(wdata_i[DW-1 -: 2]);
  assign unused_wdata = wdata_i[5];

  assign lowest_eff = cfg_q.rotate ? lowest_q : '1;

  irq_req_capture #(.N(N_IRQ)) i_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_mode_i (cfg_q.level),
    .req_i        (irq_i),
    .clr_i        (grant_set),
    .pend_o       (pend)
  );

  irq_prio_pick #(.N(N_IRQ)) i_pick_req (
    .vec_i    (pend & ~mask_q),
    .lowest_i (lowest_eff),
    .valid_o  (cand_v),
    .lvl_o    (cand_lvl),
    .rank_o   (cand_rank)
  );

  irq_prio_pick #(.N(N_IRQ)) i_pick_isr (
    .vec_i    (isr_q),
    .lowest_i (lowest_eff),
    .valid_o  (isr_v),
    .lvl_o    (isr_lvl),
    .rank_o   (isr_rank)
  );

  // Strictly above every in-service level; equal rank means same level.
  assign cand_ok = cand_v & (~isr_v | (cand_rank < isr_rank));
  assign int_o   = cand_ok & ~cfg_q.polled;

  irq_ack_seq #(.W(LW), .DW(DW)) i_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .cand_ok_i   (cand_ok),
    .cand_lvl_i  (cand_lvl),
    .base_i      (base_q),
    .grant_o     (ack_grant),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
  );

  assign poll_grant = rd_cmd & poll_q & cand_ok;
  assign grant_set  = (ack_grant | poll_grant) ? (N_IRQ'(1) << cand_lvl) : '0;

  assign eoi_lvl = wdata_i[3] ? wdata_i[LW-1:0] : isr_lvl;
  assign eoi_hit = wr_cmd & (cmd == CMD_EOI) & (wdata_i[3] | isr_v);
  assign isr_clr = eoi_hit ? (N_IRQ'(1) << eoi_lvl) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      base_q    <= '0;
      mask_q    <= '0;
      isr_q     <= '0;
      lowest_q  <= '1;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
      rdata_o   <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | grant_set;
      if (eoi_hit && cfg_q.rotate) lowest_q <= eoi_lvl;
      if (wr_mask) mask_q <= wdata_i[N_IRQ-1:0];
      if (wr_cmd) begin
        unique case (cmd)
          CMD_CFG:  cfg_q  <= cfg_t'(wdata_i[2:0]);
          CMD_BASE: base_q <= wdata_i[BW-1:0];
          CMD_EOI:  ;
          CMD_SEL: begin
            if (wdata_i[1]) poll_q <= 1'b1;
            else begin
              sel_isr_q <= wdata_i[0];
              poll_q    <= 1'b0;
            end
          end
        endcase
      end
      if (cs_i && rd_i) begin
        if (addr_i)         rdata_o <= DW'(mask_q);
        else if (poll_q)    rdata_o <= {cand_ok, {(DW-1-LW){1'b0}}, cand_lvl};
        else if (sel_isr_q) rdata_o <= DW'(isr_q);
        else                rdata_o <= DW'(pend);
        if (!addr_i) poll_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic             addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             int_o,
  input logic             ack_i,
  input logic             vec_valid_o,
  input logic             polled,
  input logic [N_IRQ-1:0] pend,
  input logic [N_IRQ-1:0] mask_q,
  input logic [N_IRQ-1:0] isr_q
);
  a_r2_mask_gates_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(pend & ~mask_q));

  a_r10_polled_no_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polled |-> !int_o);

  a_r7_vec_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i));

  a_r7_isr_set_by_ack_or_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(isr_q & ~$past(isr_q))) |-> $past(ack_i || (cs_i && rd_i && !addr_i)));

  a_r6_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_q & ~$past(isr_q)));

  a_r8_isr_clr_by_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(isr_q) & ~isr_q)) |-> $past(cs_i && wr_i && !addr_i && wdata_i[7:6] == 2'b10));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .int_o       (int_o),
  .ack_i       (ack_i),
  .vec_valid_o (vec_valid_o),
  .polled      (cfg_q.polled),
  .pend        (pend),
  .mask_q      (mask_q),
  .isr_q       (isr_q)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0, addr = 0, ack = 0;
  logic [7:0] wdata = 0, irq = 0;
  logic [7:0] rdata, vec;
  logic       int_w, vec_valid;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq),
    .int_o(int_w), .ack_i(ack), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  localparam logic [3:0] O_IRQ = 4'd0, O_WC = 4'd1, O_WM = 4'd2, O_RD0 = 4'd3,
                         O_RD1 = 4'd4, O_INT = 4'd5, O_ACK = 4'd6;
  localparam int NV = 79;
  // {op, requirement, argument, expected}
  localparam logic [23:0] VECS [NV] = '{
    {O_WC, 4'd7, 8'h41, 8'h00},  // R7 base = 1
    {O_IRQ,4'd3, 8'h04, 8'h00},
    {O_INT,4'd3, 8'h00, 8'h01},  // R3 edge request
    {O_RD0,4'd11,8'h00, 8'h04},  // R11 pending readout
    {O_IRQ,4'd3, 8'h00, 8'h00},
    {O_RD0,4'd3, 8'h00, 8'h04},  // R3 held after fall
    {O_WM, 4'd2, 8'h04, 8'h00},
    {O_INT,4'd2, 8'h00, 8'h00},  // R2 masked
    {O_RD1,4'd2, 8'h00, 8'h04},  // R2 mask readback
    {O_WM, 4'd2, 8'h00, 8'h00},
    {O_INT,4'd2, 8'h00, 8'h01},  // R2 unmasked
    {O_ACK,4'd7, 8'h00, 8'h0A},  // R7 vector
    {O_INT,4'd7, 8'h00, 8'h00},  // R7 in service
    {O_WC, 4'd11,8'hC1, 8'h00},
    {O_RD0,4'd11,8'h00, 8'h04},  // R11 in-service readout
    {O_WC, 4'd11,8'hC0, 8'h00},
    {O_RD0,4'd7, 8'h00, 8'h00},  // R7 pending cleared
    {O_IRQ,4'd6, 8'h08, 8'h00},
    {O_INT,4'd6, 8'h00, 8'h00},  // R6 lower blocked
    {O_IRQ,4'd6, 8'h09, 8'h00},
    {O_INT,4'd6, 8'h00, 8'h01},  // R6 higher nests
    {O_ACK,4'd6, 8'h00, 8'h08},  // R6
    {O_WC, 4'd11,8'hC1, 8'h00},
    {O_RD0,4'd6, 8'h00, 8'h05},  // R6 two in service
    {O_WC, 4'd8, 8'h80, 8'h00},
    {O_RD0,4'd8, 8'h00, 8'h04},  // R8 non-specific
    {O_INT,4'd8, 8'h00, 8'h00},  // R8
    {O_WC, 4'd8, 8'h8A, 8'h00},
    {O_RD0,4'd8, 8'h00, 8'h00},  // R8 specific
    {O_INT,4'd8, 8'h00, 8'h01},  // R8
    {O_ACK,4'd8, 8'h00, 8'h0B},  // R8
    {O_WC, 4'd8, 8'h80, 8'h00},
    {O_IRQ,4'd5, 8'h00, 8'h00},
    {O_IRQ,4'd5, 8'h50, 8'h00},
    {O_ACK,4'd5, 8'h00, 8'h0C},  // R5 level 4 first
    {O_WC, 4'd5, 8'h80, 8'h00},
    {O_ACK,4'd5, 8'h00, 8'h0E},  // R5 then level 6
    {O_WC, 4'd5, 8'h80, 8'h00},
    {O_INT,4'd3, 8'h00, 8'h00},  // R3 held high, no repeat
    {O_WC, 4'd9, 8'h02, 8'h00},
    {O_IRQ,4'd9, 8'h00, 8'h00},
    {O_IRQ,4'd9, 8'h11, 8'h00},
    {O_ACK,4'd9, 8'h00, 8'h08},  // R9
    {O_WC, 4'd9, 8'h80, 8'h00},
    {O_IRQ,4'd9, 8'h10, 8'h00},
    {O_IRQ,4'd9, 8'h11, 8'h00},
    {O_ACK,4'd9, 8'h00, 8'h0C},  // R9 level 4 beats 0
    {O_INT,4'd9, 8'h00, 8'h00},  // R9
    {O_WC, 4'd9, 8'h80, 8'h00},
    {O_INT,4'd9, 8'h00, 8'h01},  // R9
    {O_ACK,4'd9, 8'h00, 8'h08},  // R9
    {O_WC, 4'd9, 8'h80, 8'h00},
    {O_WC, 4'd10,8'h04, 8'h00},
    {O_IRQ,4'd10,8'h00, 8'h00},
    {O_IRQ,4'd10,8'h20, 8'h00},
    {O_INT,4'd10,8'h00, 8'h00},  // R10 output held low
    {O_WC, 4'd10,8'hC2, 8'h00},
    {O_RD0,4'd10,8'h00, 8'h85},  // R10 poll byte
    {O_RD0,4'd10,8'h00, 8'h20},  // R10 poll granted
    {O_WC, 4'd10,8'hC2, 8'h00},
    {O_RD0,4'd10,8'h00, 8'h00},  // R10 nothing to poll
    {O_WC, 4'd10,8'h80, 8'h00},
    {O_WC, 4'd10,8'h00, 8'h00},
    {O_INT,4'd10,8'h00, 8'h00},  // R10
    {O_ACK,4'd12,8'h00, 8'h0F},  // R12 no request
    {O_RD0,4'd12,8'h00, 8'h00},  // R12 no in-service bit
    {O_WC, 4'd4, 8'h01, 8'h00},
    {O_IRQ,4'd4, 8'h02, 8'h00},
    {O_INT,4'd4, 8'h00, 8'h01},  // R4 level
    {O_IRQ,4'd4, 8'h00, 8'h00},
    {O_INT,4'd4, 8'h00, 8'h00},  // R4 withdrawn
    {O_IRQ,4'd4, 8'h02, 8'h00},
    {O_INT,4'd4, 8'h00, 8'h01},  // R4
    {O_ACK,4'd4, 8'h00, 8'h09},  // R4
    {O_INT,4'd4, 8'h00, 8'h00},  // R4
    {O_WC, 4'd4, 8'h80, 8'h00},
    {O_INT,4'd4, 8'h00, 8'h01},  // R4 still high re-requests
    {O_IRQ,4'd4, 8'h00, 8'h00},
    {O_INT,4'd4, 8'h00, 8'h00}   // R4
  };

  task automatic chk(input int rq, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d got %02h expected %02h", rq, got, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic do_rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0;
    d = rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    v = vec;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] lines);
    @(negedge clk); irq = lines; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    do_reset(8'h00);
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op; logic [3:0] rq; logic [7:0] arg, exp;
      {op, rq, arg, exp} = VECS[i];
      case (op)
        O_IRQ: set_irq(arg);
        O_WC:  do_wr(1'b0, arg);
        O_WM:  do_wr(1'b1, arg);
        O_RD0: begin do_rd(1'b0, d); chk(rq, d, exp); end
        O_RD1: begin do_rd(1'b1, d); chk(rq, d, exp); end
        O_INT: begin @(negedge clk); chk(rq, {7'd0, int_w}, exp); end
        O_ACK: begin do_ack(d); chk(rq, d, exp); end
        default: ;
      endcase
    end

    // R1: reset clears state left by earlier activity
    do_wr(1'b1, 8'hAA);
    do_reset(8'h00);
    chk(1, {7'd0, int_w}, 8'h00);  // R1
    do_rd(1'b1, d); chk(1, d, 8'h00);  // R1 mask
    do_rd(1'b0, d); chk(1, d, 8'h00);  // R1 pending
    do_wr(1'b0, 8'hC1);
    do_rd(1'b0, d); chk(1, d, 8'h00);  // R1 in-service
    do_ack(d); chk(1, d, 8'h07);       // R1 base zero

    // R3/R4: lines already high at reset do not request
    do_reset(8'hFF);
    do_wr(1'b0, 8'h01);
    repeat (6) @(negedge clk);
    chk(4, {7'd0, int_w}, 8'h00);  // R4 needs a low first
    do_wr(1'b0, 8'h00);
    repeat (2) @(negedge clk);
    chk(3, {7'd0, int_w}, 8'h00);  // R3 no edge at reset
    do_wr(1'b0, 8'h01);
    set_irq(8'hFD);
    set_irq(8'hFF);
    chk(4, {7'd0, int_w}, 8'h01);  // R4 armed after low
    do_ack(d); chk(4, d, 8'h01);   // R4 level 1, base 0

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule